// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block watches a small DSP core's instruction fetch stream and its data memory accesses and raises a debug event when programmed conditions are met. It has two comparator units. Each can match on a program fetch address, or on a data read or data write at a given address whose value agrees with a programmed value on the bit positions selected by a mask. A fetch match also fires when a loop-setup instruction names the watched address as its loop end. The two unit hits are combined as unit 1 alone, unit 2 alone, unit 1 followed later by unit 2, or either unit. A pass counter then lets the event through only on a chosen occurrence.

When the event fires, the unit carries out one of four programmed actions. It can pulse a halt request to enter debug, pulse an interrupt request, set a sticky freeze for an external trace FIFO while the core keeps running, or rearm itself so that it fires again. An event pin may also toggle on every event, so that external equipment can count accesses to a location. Configuration is written through a simple single-cycle write port. A write takes effect on the next cycle whether the core is running or held in reset.

Top module: `brk_trig_unit`

## Requirements
- R1: After reset the unit is powered down (control bit 0 = 1). halt_req, irq_req, fifo_freeze and evt_pin are all 0.
- R2: While the power-down bit is 1, or while the selected unit's kind field is 00 (off), no match produces an event.
- R3: A unit of kind 01 matches a valid fetch whose address equals its address register. It also matches a valid fetch flagged as loop setup whose loop-end address equals that register.
- R4: A unit of kind 10 matches data reads and kind 11 matches data writes. The access address must equal the unit's address and (data XOR value) AND mask must be zero. Accesses in the other direction, or with a mismatch on a masked bit, do not match.
- R5: The count register (address 7) holds n-1. The event fires on the n-th qualifying match, and the earlier matches produce no action.
- R6: Combine mode 10 fires only when unit 2 matches in a cycle after a unit 1 match. A unit 2 match with no earlier unit 1 match does nothing. Each event needs a fresh unit 1 match.
- R7: Combine mode 00 uses only unit 1, mode 01 uses only unit 2, and mode 11 uses a match of either unit.
- R8: Action field (control bits 8:7) sets the response, which appears in the cycle after the matching input cycle. 00 gives a one-cycle halt_req pulse. 01 gives a one-cycle irq_req pulse. 10 sets fifo_freeze, which stays high until the next control write.
- R9: With action 11 the count reloads from its programmed value after each event, so events repeat every n matches. With actions 00 to 10 the unit fires once and stays quiet until the control register is written again.
- R10: With pin enable (control bit 9) set, evt_pin toggles on every event. With it clear, evt_pin holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 control, 1/2 address of unit 1/2, 3/4 value/mask of unit 1, 5/6 value/mask of unit 2, 7 count |
| cfg_wdata | input | DW | Write data |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | AW | Fetch address |
| fetch_loop_setup | input | 1 | The fetched instruction sets up a hardware loop |
| loop_end_addr | input | AW | Last address of the loop being set up |
| dmem_valid | input | 1 | A data access is presented this cycle |
| dmem_write | input | 1 | 1 write, 0 read |
| dmem_addr | input | AW | Data address |
| dmem_data | input | DW | Data read or written |
| halt_req | output | 1 | One-cycle request to halt into debug |
| irq_req | output | 1 | One-cycle interrupt request |
| fifo_freeze | output | 1 | Sticky trace FIFO freeze |
| evt_pin | output | 1 | Event pin, toggles per event when enabled |

## Verification
The bench targets the loop-setup alias, where a design that compares only the fetch address would miss the breakpoint at loop entry. It covers the wrong access direction and a mismatch hidden or exposed by the mask, which a design with inverted mask polarity would get wrong. It checks the off-by-one in the n-1 count, where a design would fire one match early or late. Sequence order is also tested: a unit 2 hit before unit 1 would fire a wrong design. Finally it covers one-shot against rearm behaviour and pin toggling, where a faulty unit would either fall silent after its first event or keep firing when it should not.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {KIND_OFF, KIND_FETCH, KIND_DRD, KIND_DWR} kind_e;
  typedef enum logic [1:0] {CMB_U1, CMB_U2, CMB_SEQ, CMB_ANY} cmb_e;
  typedef enum logic [1:0] {ACT_HALT, ACT_IRQ, ACT_FREEZE, ACT_REARM} act_e;

  // bit 0 = power down, 2:1 kind1, 4:3 kind2, 6:5 combine, 8:7 action, 9 pin enable
  typedef struct packed {
    logic  pin_en;
    act_e  act;
    cmb_e  cmb;
    kind_e k2;
    kind_e k1;
    logic  pwd;
  } ctrl_t;

  localparam int CTRL_W = 10;
  localparam logic [2:0] RA_CTRL = 3'd0, RA_ADR1 = 3'd1, RA_ADR2 = 3'd2,
                         RA_VAL1 = 3'd3, RA_MSK1 = 3'd4, RA_VAL2 = 3'd5,
                         RA_MSK2 = 3'd6, RA_CNT  = 3'd7;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  brk_pkg::kind_e kind,
  input  logic [AW-1:0]  ref_addr,
  input  logic [DW-1:0]  ref_val,
  input  logic [DW-1:0]  ref_mask,
  input  logic           fetch_valid,
  input  logic [AW-1:0]  fetch_addr,
  input  logic           fetch_loop_setup,
  input  logic [AW-1:0]  loop_end_addr,
  input  logic           dmem_valid,
  input  logic           dmem_write,
  input  logic [AW-1:0]  dmem_addr,
  input  logic [DW-1:0]  dmem_data,
  output logic           hit
);
  import brk_pkg::*;

  function automatic logic value_agrees(input logic [DW-1:0] v, input logic [DW-1:0] m,
                                        input logic [DW-1:0] d);
    return ((d ^ v) & m) == '0;
  endfunction

  logic fetch_hit, data_hit;

  always_comb begin
    fetch_hit = fetch_valid &&
                ((fetch_addr == ref_addr) || (fetch_loop_setup && (loop_end_addr == ref_addr)));
    data_hit  = dmem_valid && (dmem_addr == ref_addr) && value_agrees(ref_val, ref_mask, dmem_data);
    unique case (kind)
      KIND_FETCH: hit = fetch_hit;
      KIND_DRD:   hit = data_hit && !dmem_write;
      KIND_DWR:   hit = data_hit && dmem_write;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brk_seq_cnt.sv
module brk_seq_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  brk_pkg::cmb_e cmb,
  input  logic          rearm,
  input  logic          hit1,
  input  logic          hit2,
  input  logic          ctrl_wr,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  output logic          evt,
  output logic [CW-1:0] cnt,
  output logic          seq_pend
);
  import brk_pkg::*;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  logic [CW-1:0] shadow_q;
  logic          armed_q;
  logic          qual;

  always_comb begin
    unique case (cmb)
      CMB_U1:  qual = hit1;
      CMB_U2:  qual = hit2;
      CMB_SEQ: qual = seq_pend && hit2;
      default: qual = hit1 || hit2;
    endcase
    qual = qual && enable && armed_q;
    evt  = qual && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shadow_q <= '0;
      armed_q  <= 1'b1;
      seq_pend <= 1'b0;
    end else begin
      if (cnt_wr) begin
        cnt      <= cnt_wdata;
        shadow_q <= cnt_wdata;
      end else if (evt && rearm) begin
        cnt <= shadow_q;
      end else if (qual) begin
        cnt <= step_down(cnt);
      end

      if (ctrl_wr)              armed_q <= 1'b1;
      else if (evt && !rearm)   armed_q <= 1'b0;

      if (ctrl_wr || cmb != CMB_SEQ)          seq_pend <= 1'b0;
      else if (qual)                          seq_pend <= 1'b0;
      else if (hit1 && enable && armed_q)     seq_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/brk_action.sv
module brk_action (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  brk_pkg::act_e act,
  input  logic          pin_en,
  input  logic          ctrl_wr,
  output logic          halt_req,
  output logic          irq_req,
  output logic          fifo_freeze,
  output logic          evt_pin
);
  import brk_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req    <= 1'b0;
      irq_req     <= 1'b0;
      fifo_freeze <= 1'b0;
      evt_pin     <= 1'b0;
    end else begin
      halt_req <= evt && (act == ACT_HALT);
      irq_req  <= evt && (act == ACT_IRQ);
      if (ctrl_wr)                            fifo_freeze <= 1'b0;
      else if (evt && act == ACT_FREEZE)      fifo_freeze <= 1'b1;
      if (evt && pin_en)                      evt_pin <= !evt_pin;
    end
  end
endmodule

// File: rtl/brk_trig_unit.sv
module brk_trig_unit #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_loop_setup,
  input  logic [AW-1:0] loop_end_addr,
  input  logic          dmem_valid,
  input  logic          dmem_write,
  input  logic [AW-1:0] dmem_addr,
  input  logic [DW-1:0] dmem_data,
  output logic          halt_req,
  output logic          irq_req,
  output logic          fifo_freeze,
  output logic          evt_pin
);
  import brk_pkg::*;

  localparam int NU = 2;
  localparam int CW = DW;

  ctrl_t         ctrl_q;
  logic [AW-1:0] adr_q [NU];
  logic [DW-1:0] val_q [NU];
  logic [DW-1:0] msk_q [NU];
  logic [NU-1:0] hit_w;
  kind_e         kind_w [NU];
  logic          ctrl_wr_w, cnt_wr_w, evt_w, seq_pend_w, pwd_w, pin_en_w;
  logic [CW-1:0] cnt_w;

  assign ctrl_wr_w = cfg_we && (cfg_addr == RA_CTRL);
  assign cnt_wr_w  = cfg_we && (cfg_addr == RA_CNT);
  assign kind_w[0] = ctrl_q.k1;
  assign kind_w[1] = ctrl_q.k2;
  assign pwd_w     = ctrl_q.pwd;
  assign pin_en_w  = ctrl_q.pin_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_W'(1));
      for (int i = 0; i < NU; i++) begin
        adr_q[i] <= '0;
        val_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else if (cfg_we) begin
      unique case (cfg_addr)
        RA_CTRL: ctrl_q   <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        RA_ADR1: adr_q[0] <= cfg_wdata[AW-1:0];
        RA_ADR2: adr_q[1] <= cfg_wdata[AW-1:0];
        RA_VAL1: val_q[0] <= cfg_wdata;
        RA_MSK1: msk_q[0] <= cfg_wdata;
        RA_VAL2: val_q[1] <= cfg_wdata;
        RA_MSK2: msk_q[1] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    brk_cmp #(.AW(AW), .DW(DW)) cmp (
      .kind(kind_w[u]), .ref_addr(adr_q[u]), .ref_val(val_q[u]), .ref_mask(msk_q[u]),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .fetch_loop_setup(fetch_loop_setup), .loop_end_addr(loop_end_addr),
      .dmem_valid(dmem_valid), .dmem_write(dmem_write), .dmem_addr(dmem_addr),
      .dmem_data(dmem_data), .hit(hit_w[u])
    );
  end

  brk_seq_cnt #(.CW(CW)) seq (
    .clk(clk), .rst_n(rst_n), .enable(!ctrl_q.pwd), .cmb(ctrl_q.cmb),
    .rearm(ctrl_q.act == ACT_REARM), .hit1(hit_w[0]), .hit2(hit_w[1]),
    .ctrl_wr(ctrl_wr_w), .cnt_wr(cnt_wr_w), .cnt_wdata(cfg_wdata[CW-1:0]),
    .evt(evt_w), .cnt(cnt_w), .seq_pend(seq_pend_w)
  );

  brk_action act (
    .clk(clk), .rst_n(rst_n), .evt(evt_w), .act(ctrl_q.act), .pin_en(ctrl_q.pin_en),
    .ctrl_wr(ctrl_wr_w), .halt_req(halt_req), .irq_req(irq_req),
    .fifo_freeze(fifo_freeze), .evt_pin(evt_pin)
  );
endmodule

// File: rtl/brk_trig_chk.sv
module brk_trig_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt,
  input logic [CW-1:0] cnt,
  input logic          pwd,
  input logic          pin_en,
  input logic          halt_req,
  input logic          irq_req,
  input logic          fifo_freeze,
  input logic          evt_pin
);
  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, irq_req}));

  // R8
  halt_after_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(evt));

  // R8
  freeze_after_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_freeze) |-> $past(evt));

  // R2
  pwd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwd |=> !(halt_req || irq_req));

  // R5
  evt_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (cnt == '0));

  // R10
  pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evt_pin) |-> $past(evt && pin_en));
endmodule

bind brk_trig_unit brk_trig_chk #(.CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .evt(evt_w), .cnt(cnt_w), .pwd(pwd_w), .pin_en(pin_en_w),
  .halt_req(halt_req), .irq_req(irq_req), .fifo_freeze(fifo_freeze), .evt_pin(evt_pin)
);

// File: tb/brk_trig_unit_test.sv
module brk_trig_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_loop_setup = 1'b0;
  logic [AW-1:0] loop_end_addr = '0;
  logic          dmem_valid = 1'b0;
  logic          dmem_write = 1'b0;
  logic [AW-1:0] dmem_addr = '0;
  logic [DW-1:0] dmem_data = '0;
  logic          halt_req, irq_req, fifo_freeze, evt_pin;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_trig_unit #(.AW(AW), .DW(DW)) uut (.*);

  // control word: pwd bit0, kind1 2:1, kind2 4:3, combine 6:5, action 8:7, pin_en 9
  function automatic logic [DW-1:0] ctl(input int pwd, input int k1, input int k2,
                                        input int cmb, input int act, input int pe);
    logic [DW-1:0] w;
    w = '0;
    w[0] = pwd[0]; w[2:1] = k1[1:0]; w[4:3] = k2[1:0];
    w[6:5] = cmb[1:0]; w[8:7] = act[1:0]; w[9] = pe[0];
    return w;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one fetch cycle; outputs sampled just after the edge that registers it
  task automatic fetch(input logic [AW-1:0] a, input logic ls, input logic [AW-1:0] le);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; fetch_loop_setup = ls; loop_end_addr = le;
    @(posedge clk); #1;
    fetch_valid = 1'b0; fetch_loop_setup = 1'b0;
  endtask

  task automatic dacc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    dmem_valid = 1'b1; dmem_write = w; dmem_addr = a; dmem_data = d;
    @(posedge clk); #1;
    dmem_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 halt", halt_req, 1'b0);
    check("R1 irq", irq_req, 1'b0);
    check("R1 freeze", fifo_freeze, 1'b0);
    check("R1 pin", evt_pin, 1'b0);
    wr(3'd1, 16'h0100);
    wr(3'd7, 16'd0);
    fetch(16'h0100, 1'b0, '0);
    check("R1 powered down after reset", irq_req || halt_req, 1'b0);
  endtask

  task automatic t_disabled;
    wr(3'd0, ctl(1, 1, 0, 0, 1, 0));
    fetch(16'h0100, 1'b0, '0);
    check("R2 pwd blocks", irq_req, 1'b0);
    wr(3'd0, ctl(0, 0, 0, 0, 1, 0));
    fetch(16'h0100, 1'b0, '0);
    check("R2 kind off blocks", irq_req, 1'b0);
  endtask

  task automatic t_fetch_loop;
    wr(3'd7, 16'd0);
    wr(3'd0, ctl(0, 1, 0, 0, 1, 0));
    fetch(16'h0101, 1'b0, '0);
    check("R3 other address", irq_req, 1'b0);
    fetch(16'h0100, 1'b0, '0);
    check("R3 address hit", irq_req, 1'b1);
    @(posedge clk); #1;
    check("R8 irq one cycle", irq_req, 1'b0);
    fetch(16'h0100, 1'b0, '0);
    check("R9 one-shot quiet", irq_req, 1'b0);
    wr(3'd0, ctl(0, 1, 0, 0, 1, 0));
    fetch(16'h00F0, 1'b0, 16'h0100);
    check("R3 loop end without setup flag", irq_req, 1'b0);
    fetch(16'h00F0, 1'b1, 16'h0100);
    check("R3 loop setup alias", irq_req, 1'b1);
  endtask

  task automatic t_data;
    wr(3'd1, 16'h0020);
    wr(3'd3, 16'h12AB);
    wr(3'd4, 16'hFF00);
    wr(3'd7, 16'd0);
    wr(3'd0, ctl(0, 3, 0, 0, 1, 0));
    dacc(1'b0, 16'h0020, 16'h1234);
    check("R4 read ignored by write kind", irq_req, 1'b0);
    dacc(1'b1, 16'h0020, 16'h3334);
    check("R4 masked bit mismatch", irq_req, 1'b0);
    dacc(1'b1, 16'h0021, 16'h1234);
    check("R4 other address", irq_req, 1'b0);
    dacc(1'b1, 16'h0020, 16'h12FF);
    check("R4 masked write hit", irq_req, 1'b1);
    wr(3'd0, ctl(0, 2, 0, 0, 1, 0));
    dacc(1'b1, 16'h0020, 16'h1200);
    check("R4 write ignored by read kind", irq_req, 1'b0);
    dacc(1'b0, 16'h0020, 16'h1200);
    check("R4 read hit", irq_req, 1'b1);
  endtask

  task automatic t_count;
    wr(3'd1, 16'h0100);
    wr(3'd7, 16'd2);
    wr(3'd0, ctl(0, 1, 0, 0, 1, 0));
    fetch(16'h0100, 1'b0, '0);
    check("R5 match 1 of 3", irq_req, 1'b0);
    fetch(16'h0100, 1'b0, '0);
    check("R5 match 2 of 3", irq_req, 1'b0);
    fetch(16'h0100, 1'b0, '0);
    check("R5 match 3 of 3", irq_req, 1'b1);
  endtask

  task automatic t_seq;
    wr(3'd2, 16'h0200);
    wr(3'd7, 16'd0);
    wr(3'd0, ctl(0, 1, 1, 2, 1, 0));
    fetch(16'h0200, 1'b0, '0);
    check("R6 unit2 first", irq_req, 1'b0);
    fetch(16'h0100, 1'b0, '0);
    check("R6 unit1 alone", irq_req, 1'b0);
    fetch(16'h0200, 1'b0, '0);
    check("R6 unit1 then unit2", irq_req, 1'b1);
  endtask

  task automatic t_combine;
    wr(3'd0, ctl(0, 1, 1, 1, 1, 0));
    fetch(16'h0100, 1'b0, '0);
    check("R7 unit2-only ignores unit1", irq_req, 1'b0);
    fetch(16'h0200, 1'b0, '0);
    check("R7 unit2-only hit", irq_req, 1'b1);
    wr(3'd0, ctl(0, 1, 1, 3, 1, 0));
    fetch(16'h0200, 1'b0, '0);
    check("R7 either via unit2", irq_req, 1'b1);
    wr(3'd0, ctl(0, 1, 1, 3, 1, 0));
    fetch(16'h0100, 1'b0, '0);
    check("R7 either via unit1", irq_req, 1'b1);
  endtask

  task automatic t_actions;
    wr(3'd0, ctl(0, 1, 0, 0, 0, 0));
    fetch(16'h0100, 1'b0, '0);
    check("R8 halt pulse", halt_req, 1'b1);
    check("R8 no irq with halt", irq_req, 1'b0);
    wr(3'd0, ctl(0, 1, 0, 0, 2, 0));
    fetch(16'h0100, 1'b0, '0);
    check("R8 freeze set", fifo_freeze, 1'b1);
    check("R8 freeze no halt", halt_req, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    check("R8 freeze sticky", fifo_freeze, 1'b1);
    wr(3'd0, ctl(0, 1, 0, 0, 2, 0));
    check("R8 freeze cleared by control write", fifo_freeze, 1'b0);
  endtask

  task automatic t_rearm;
    logic p0;
    wr(3'd7, 16'd1);
    wr(3'd0, ctl(0, 1, 0, 0, 3, 1));
    p0 = evt_pin;
    fetch(16'h0100, 1'b0, '0);
    check("R9 rearm first pass", evt_pin, p0);
    fetch(16'h0100, 1'b0, '0);
    check("R10 pin toggles", evt_pin, !p0);
    check("R9 rearm no irq", irq_req, 1'b0);
    fetch(16'h0100, 1'b0, '0);
    check("R9 count reloaded", evt_pin, !p0);
    fetch(16'h0100, 1'b0, '0);
    check("R9 fires again", evt_pin, p0);
    wr(3'd0, ctl(0, 1, 0, 0, 3, 0));
    fetch(16'h0100, 1'b0, '0);
    fetch(16'h0100, 1'b0, '0);
    check("R10 pin held when disabled", evt_pin, p0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_disabled;
    t_fetch_loop;
    t_data;
    t_count;
    t_seq;
    t_combine;
    t_actions;
    t_rearm;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule